// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Interface

This block is the control-word front end of a frequency synthesizer. A host shifts a 22-bit control word in over three wires: a serial clock, a serial data line and a load enable. When the load enable drops, a two-bit address field at the bottom of the word picks one of three holding buffers to receive it. One buffer holds the reference-divider setting. The other two each hold a complete local-oscillator divider setting.

A separate level input, `lo_sel`, picks which of the two stored local-oscillator words drives the divider outputs. The other word stays stored. External logic can therefore hop between two channel frequencies at once, with no traffic on the serial bus. All decoded fields leave the block through registers, so the divider chain never sees a partly written word.

The serial wires are sampled by the system clock `clk`. They are assumed to be slow next to it and already synchronous to it: each serial clock phase spans several `clk` cycles. Reset is synchronous and active low.

Top module: `synth_prog_if`

## Requirements
- R1: While `ser_en` is high, each rising edge of `ser_clk` shifts `ser_data` into a 22-bit shift register, most significant bit first. The last bit shifted ends up in bit 0.
- R2: On the falling edge of `ser_en`, the shift register is copied into the buffer named by bits [1:0]. Code 2'b01 selects the reference buffer, 2'b10 selects local-oscillator word 1 and 2'b11 selects local-oscillator word 2.
- R3: A word with address code 2'b00 is discarded and leaves all three buffers and all outputs unchanged.
- R4: Only the last 22 bits shifted count, whatever the number of `ser_clk` edges in a window. With more than 22 edges, the earliest bits fall off. With fewer, bits left from earlier windows fill the upper positions.
- R5: The reference word is decoded as follows: `ref_count` from bits [14:2], `mod_sel` from bit 15, `cp_gain` from bits [17:16] and `tmux_sel` from bits [19:18]. Bits [21:20] are ignored.
- R6: A local-oscillator word is decoded as follows: `swallow` from bits [5:2], `main_count` from bits [20:6] and `pd_sense` from bit 21.
- R7: With `lo_sel` low, the local-oscillator outputs show word 1. With `lo_sel` high, they show word 2. Switching does not alter either stored word.
- R8: Take the first rising `clk` edge that samples `ser_en` low after it was high. The outputs take the new word on the third rising `clk` edge counting from that one, and not before. A change on `lo_sel` reaches the outputs on the second rising edge, counting the edge that first samples it.
- R9: While `rst_n` is low at a rising `clk` edge, all buffers, the shift register and all outputs are cleared to zero.
- R10: `ser_clk` edges while `ser_en` is low shift nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_en | input | 1 | Load window; a falling edge commits the word |
| lo_sel | input | 1 | Selects local-oscillator word 1 (low) or 2 (high) |
| ref_count | output | 13 | Reference divider count |
| mod_sel | output | 1 | Prescaler modulus select |
| cp_gain | output | 2 | Charge-pump gain control |
| tmux_sel | output | 2 | Test multiplexer select |
| swallow | output | 4 | Swallow (A) count of the active word |
| main_count | output | 15 | Main (M) count of the active word |
| pd_sense | output | 1 | Phase-detector sense of the active word |

## Verification
Two events can meet in the same cycle: a commit into local-oscillator word 2 and a flip of `lo_sel` toward that same word. The bench drops `ser_en` and raises `lo_sel` on the same `clk` edge. It then checks the outputs one edge at a time. After the second edge they must show the old contents of word 2. After the third edge they must show the new contents, and never a mixture. A second overlap occurs when `ser_clk` pulses arrive after the window has closed. The bench follows them with an empty window and confirms that the rewritten buffer holds the original word.

// File: rtl/synth_prog_pkg.sv
// Shared widths, field positions, address codes and field types for the
// synthesizer programming interface. Assumes a 2-bit address in the low bits.
package synth_prog_pkg;
    parameter int WORD_W = 22;
    parameter int ADR_W  = 2;
    parameter int REF_W  = 13;
    parameter int CP_W   = 2;
    parameter int TM_W   = 2;
    parameter int A_W    = 4;
    parameter int M_W    = 15;
    parameter int LO_N   = 2;

    localparam int REF_LSB = ADR_W;
    localparam int MS_POS  = REF_LSB + REF_W;
    localparam int CP_LSB  = MS_POS + 1;
    localparam int TM_LSB  = CP_LSB + CP_W;
    localparam int A_LSB   = ADR_W;
    localparam int M_LSB   = A_LSB + A_W;
    localparam int SN_POS  = M_LSB + M_W;

    localparam logic [ADR_W-1:0] ADR_NONE    = 2'd0;
    localparam logic [ADR_W-1:0] ADR_REF     = 2'd1;
    localparam logic [ADR_W-1:0] ADR_LO_BASE = 2'd2;

    typedef struct packed {
        logic [TM_W-1:0]  tmux;
        logic [CP_W-1:0]  cp;
        logic             ms;
        logic [REF_W-1:0] r;
    } ref_fields_t;

    typedef struct packed {
        logic             sense;
        logic [M_W-1:0]   m;
        logic [A_W-1:0]   a;
    } lo_fields_t;

    function automatic ref_fields_t to_ref(input logic [WORD_W-1:0] w);
        ref_fields_t f;
        f.r    = w[REF_LSB +: REF_W];
        f.ms   = w[MS_POS];
        f.cp   = w[CP_LSB +: CP_W];
        f.tmux = w[TM_LSB +: TM_W];
        return f;
    endfunction

    function automatic lo_fields_t to_lo(input logic [WORD_W-1:0] w);
        lo_fields_t f;
        f.a     = w[A_LSB +: A_W];
        f.m     = w[M_LSB +: M_W];
        f.sense = w[SN_POS];
        return f;
    endfunction
endpackage

// File: rtl/three_wire_rx.sv
// Samples the three serial wires with the system clock, shifts MSB-first on
// sampled serial-clock rises inside the enable window, and pulses load_stb
// for one cycle when the sampled enable falls. Assumes slow serial wires.
module three_wire_rx
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_en,
    output logic [WORD_W-1:0] shreg,
    output logic              en_s,
    output logic              load_stb
);
    logic clk_s, dat_s, clk_d, en_d;
    logic shift_now;

    // Input sampling stage for the three wires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_s <= 1'b0;
            dat_s <= 1'b0;
            en_s  <= 1'b0;
        end else begin
            clk_s <= ser_clk;
            dat_s <= ser_data;
            en_s  <= ser_en;
        end
    end

    // Delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d <= 1'b0;
            en_d  <= 1'b0;
        end else begin
            clk_d <= clk_s;
            en_d  <= en_s;
        end
    end

    // Edge decode: shift on clock rise in window, commit on enable fall.
    always_comb begin
        shift_now = clk_s & ~clk_d & en_s;
        load_stb  = en_d & ~en_s;
    end

    // Serial shift register, newest bit enters at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)         shreg <= '0;
        else if (shift_now) shreg <= {shreg[WORD_W-2:0], dat_s};
    end
endmodule

// File: rtl/word_bank.sv
// Three holding buffers steered by the word's address field: one reference
// word and LO_N local-oscillator words. An unused address writes nothing.
module word_bank
    import synth_prog_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_stb,
    input  logic [WORD_W-1:0]      word,
    output ref_fields_t            ref_buf,
    output lo_fields_t [LO_N-1:0]  lo_buf
);
    logic [ADR_W-1:0] adr;
    assign adr = word[ADR_W-1:0];

    // Reference buffer write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ref_buf <= '0;
        else if (load_stb && adr == ADR_REF) ref_buf <= to_ref(word);
    end

    for (genvar g = 0; g < LO_N; g++) begin : g_lo
        localparam logic [ADR_W-1:0] MY_ADR = ADR_LO_BASE + ADR_W'(g);
        lo_fields_t lo_q;
        // Local-oscillator buffer write for this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                         lo_q <= '0;
            else if (load_stb && adr == MY_ADR) lo_q <= to_lo(word);
        end
        assign lo_buf[g] = lo_q;
    end
endmodule

// File: rtl/field_out.sv
// Registers the decoded fields toward the divider chain and picks the
// active local-oscillator word with a registered copy of the select level.
module field_out
    import synth_prog_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lo_sel,
    input  ref_fields_t            ref_buf,
    input  lo_fields_t [LO_N-1:0]  lo_buf,
    output ref_fields_t            ref_o,
    output lo_fields_t             lo_o
);
    logic sel_q;

    // Sample the select level.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= lo_sel;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_o <= '0;
            lo_o  <= '0;
        end else begin
            ref_o <= ref_buf;
            lo_o  <= lo_buf[sel_q];
        end
    end
endmodule

// File: rtl/synth_prog_if.sv
// Top of the three-wire programming interface: receiver, steered word bank
// and registered field outputs. Assumes serial wires synchronous to clk.
module synth_prog_if
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_en,
    input  logic              lo_sel,
    output logic [REF_W-1:0]  ref_count,
    output logic              mod_sel,
    output logic [CP_W-1:0]   cp_gain,
    output logic [TM_W-1:0]   tmux_sel,
    output logic [A_W-1:0]    swallow,
    output logic [M_W-1:0]    main_count,
    output logic              pd_sense
);
    logic [WORD_W-1:0]     shreg;
    logic                  en_s;
    logic                  load_stb;
    ref_fields_t           ref_buf;
    lo_fields_t [LO_N-1:0] lo_buf;
    ref_fields_t           ref_o;
    lo_fields_t            lo_o;

    three_wire_rx u_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .shreg(shreg), .en_s(en_s), .load_stb(load_stb)
    );

    word_bank u_bank (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .word(shreg),
        .ref_buf(ref_buf), .lo_buf(lo_buf)
    );

    field_out u_out (
        .clk(clk), .rst_n(rst_n), .lo_sel(lo_sel), .ref_buf(ref_buf),
        .lo_buf(lo_buf), .ref_o(ref_o), .lo_o(lo_o)
    );

    // Unpack registered fields onto the ports.
    always_comb begin
        ref_count  = ref_o.r;
        mod_sel    = ref_o.ms;
        cp_gain    = ref_o.cp;
        tmux_sel   = ref_o.tmux;
        swallow    = lo_o.a;
        main_count = lo_o.m;
        pd_sense   = lo_o.sense;
    end
endmodule

// File: rtl/synth_prog_chk.sv
// Property checker for synth_prog_if, bound to every instance of the top.
module synth_prog_chk
    import synth_prog_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lo_sel,
    input logic                   en_s,
    input logic                   load_stb,
    input logic [WORD_W-1:0]      shreg,
    input ref_fields_t            ref_buf,
    input lo_fields_t [LO_N-1:0]  lo_buf,
    input logic [REF_W-1:0]       ref_count,
    input logic                   mod_sel,
    input logic [CP_W-1:0]        cp_gain,
    input logic [TM_W-1:0]        tmux_sel,
    input logic [A_W-1:0]         swallow,
    input logic [M_W-1:0]         main_count,
    input logic                   pd_sense
);
    p_ref_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ref_count, mod_sel, cp_gain, tmux_sel}) |-> $past(load_stb, 2));

    p_lo_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({swallow, main_count, pd_sense})
            |-> ($past(load_stb, 2) || ($past(lo_sel, 2) != $past(lo_sel, 3))));

    p_unused_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && shreg[ADR_W-1:0] == ADR_NONE) |=> ($stable(ref_buf) && $stable(lo_buf)));

    p_shift_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> $stable(shreg));

    p_hold_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> ($stable(ref_buf) && $stable(lo_buf)));
endmodule

bind synth_prog_if synth_prog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lo_sel(lo_sel), .en_s(en_s),
    .load_stb(load_stb), .shreg(shreg), .ref_buf(ref_buf), .lo_buf(lo_buf),
    .ref_count(ref_count), .mod_sel(mod_sel), .cp_gain(cp_gain),
    .tmux_sel(tmux_sel), .swallow(swallow), .main_count(main_count),
    .pd_sense(pd_sense)
);

// File: tb/tb_synth_prog_if.sv
`timescale 1ns/1ps
module tb_synth_prog_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0, lo_sel = 1'b0;
    logic [12:0] ref_count;
    logic        mod_sel;
    logic [1:0]  cp_gain, tmux_sel;
    logic [3:0]  swallow;
    logic [14:0] main_count;
    logic        pd_sense;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    synth_prog_if dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .lo_sel(lo_sel), .ref_count(ref_count),
        .mod_sel(mod_sel), .cp_gain(cp_gain), .tmux_sel(tmux_sel),
        .swallow(swallow), .main_count(main_count), .pd_sense(pd_sense)
    );

    function automatic logic [21:0] mk_ref(logic [12:0] r, logic ms, logic [1:0] cp, logic [1:0] tm);
        return {2'b00, tm, cp, ms, r, 2'b01};
    endfunction
    function automatic logic [21:0] mk_lo(logic [3:0] a, logic [14:0] m, logic s, logic second);
        return {s, m, a, second ? 2'b11 : 2'b10};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_ref(string req, logic [21:0] w);
        check(req, "ref_count", 32'(ref_count), 32'(w[14:2]));
        check(req, "mod_sel",   32'(mod_sel),   32'(w[15]));
        check(req, "cp_gain",   32'(cp_gain),   32'(w[17:16]));
        check(req, "tmux_sel",  32'(tmux_sel),  32'(w[19:18]));
    endtask

    task automatic check_lo(string req, logic [21:0] w);
        check(req, "swallow",    32'(swallow),    32'(w[5:2]));
        check(req, "main_count", 32'(main_count), 32'(w[20:6]));
        check(req, "pd_sense",   32'(pd_sense),   32'(w[21]));
    endtask

    task automatic ser_bit(logic b);
        @(negedge clk) ser_data = b;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (2) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic open_win();
        @(negedge clk) ser_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) ser_bit(v[i]);
    endtask

    task automatic close_win();
        @(negedge clk) ser_en = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic load(logic [21:0] w);
        open_win();
        send_bits(32'(w), 22);
        close_win();
    endtask

    task automatic set_sel(logic s);
        @(negedge clk) lo_sel = s;
        repeat (3) @(negedge clk);
    endtask

    // R9: reset state.
    task automatic t_reset();
        @(negedge clk);
        check_ref("R9", 22'h0);
        check_lo("R9", 22'h0);
    endtask

    // R1 R2 R5: reference word decode.
    task automatic t_ref();
        logic [21:0] w = mk_ref(13'h1A5B, 1'b1, 2'd2, 2'd3);
        load(w);
        check_ref("R5", w);
        check_lo("R2", 22'h0);
    endtask

    // R2 R6 R7: both LO words and select toggling.
    task automatic t_lo();
        logic [21:0] w1 = mk_lo(4'h9, 15'h5A3C, 1'b1, 1'b0);
        logic [21:0] w2 = mk_lo(4'h6, 15'h21F0, 1'b0, 1'b1);
        load(w1);
        load(w2);
        set_sel(1'b0); check_lo("R6", w1);
        set_sel(1'b1); check_lo("R7", w2);
        set_sel(1'b0); check_lo("R7", w1);
    endtask

    // R8: output timing of a commit and of a select change.
    task automatic t_timing();
        logic [21:0] w = mk_ref(13'h0C37, 1'b0, 2'd1, 2'd0);
        logic [21:0] old = mk_ref(13'h1A5B, 1'b1, 2'd2, 2'd3);
        logic [21:0] w2 = mk_lo(4'h6, 15'h21F0, 1'b0, 1'b1);
        logic [21:0] w1 = mk_lo(4'h9, 15'h5A3C, 1'b1, 1'b0);
        open_win();
        send_bits(32'(w), 22);
        @(negedge clk) ser_en = 1'b0;
        @(negedge clk); check_ref("R8", old);
        @(negedge clk); check_ref("R8", old);
        @(negedge clk); check_ref("R8", w);
        @(negedge clk) lo_sel = 1'b1;
        @(negedge clk); check_lo("R8", w1);
        @(negedge clk); check_lo("R8", w2);
        set_sel(1'b0);
    endtask

    // R3: unused address code is dropped.
    task automatic t_unused();
        logic [21:0] cur = mk_ref(13'h0C37, 1'b0, 2'd1, 2'd0);
        logic [21:0] w2 = mk_lo(4'h6, 15'h21F0, 1'b0, 1'b1);
        load({20'hFFFFF, 2'b00});
        check_ref("R3", cur);
        set_sel(1'b1); check_lo("R3", w2);
        set_sel(1'b0); check_lo("R3", mk_lo(4'h9, 15'h5A3C, 1'b1, 1'b0));
    endtask

    // R4: long and short windows keep the last 22 bits.
    task automatic t_length();
        logic [21:0] w = mk_ref(13'h0777, 1'b1, 2'd3, 2'd1);
        logic [21:0] nw;
        open_win();
        send_bits(32'hB, 4);
        send_bits(32'(w), 22);
        close_win();
        check_ref("R4", w);
        open_win();
        send_bits(32'h2A5, 10);
        close_win();
        nw = {w[11:0], 10'h2A5};
        check_ref("R4", nw);
    endtask

    // R10: serial clocks with enable low shift nothing.
    task automatic t_gate();
        logic [21:0] w = mk_ref(13'h1234, 1'b0, 2'd2, 2'd2);
        logic [21:0] w2 = mk_lo(4'h6, 15'h21F0, 1'b0, 1'b1);
        load(w);
        for (int i = 0; i < 3; i++) ser_bit(1'b1);
        open_win();
        close_win();
        check_ref("R10", w);
        set_sel(1'b1); check_lo("R10", w2);
        set_sel(1'b0);
    endtask

    // R7 R8: commit to word 2 in the same cycle the select moves to it.
    task automatic t_collide();
        logic [21:0] w2o = mk_lo(4'h6, 15'h21F0, 1'b0, 1'b1);
        logic [21:0] w2n = mk_lo(4'hC, 15'h0F0F, 1'b1, 1'b1);
        open_win();
        send_bits(32'(w2n), 22);
        @(negedge clk) begin ser_en = 1'b0; lo_sel = 1'b1; end
        @(negedge clk);
        @(negedge clk); check_lo("R8", w2o);
        @(negedge clk); check_lo("R7", w2n);
        set_sel(1'b0); check_lo("R7", mk_lo(4'h9, 15'h5A3C, 1'b1, 1'b0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_ref();
        t_lo();
        t_timing();
        t_unused();
        t_length();
        t_gate();
        t_collide();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule